// File: doc/BRIEF.md
# Regulator Startup and Power-Good Supervisor

This block is the digital supervisor of a step-down regulator. It reads comparator flags that other circuitry has already digitized: two supply-level flags (power-on-reset level reached, undervoltage-lockout level reached), two output-window flags (above the upper limit, below the lower limit) and a fault detect. It also reads a shutdown request, the slew mask from the voltage-transition sequencer, and a ramp-complete flag. Every flag passes through a configurable synchronizer before it is used.

The supervisor holds the low-side gate on and keeps power-good low while the supply is under the lockout level. Once the supply clears lockout, it samples the voltage-setting inputs once, starts the output ramp, and regulates once the ramp reports completion. A fault latch records a fault seen during startup or regulation. Only a shutdown request or a supply drop below the power-on-reset level clears it. Power-good is resolved by a fixed priority: undervoltage, then latched fault, then startup or shutdown, then the slew mask, then the output window.

Top module: `supply_supervisor`

## Requirements
- R1: After reset, and whenever the synchronized power-on-reset flag is low, powerGood is 0, lowGateForce is 1, faultLatched is 0, rampStart is 0 and dacSample is not pulsed.
- R2: While porOk is 1 and uvloOk is 0, powerGood is 0 and lowGateForce is 1 for every combination of overWin, underWin and slewMask.
- R3: When uvloOk rises with porOk high, shutdownReq low and no fault latched, dacSample pulses for exactly one cycle, once. rampStart goes to 1 and lowGateForce goes to 0.
- R4: During startup (rampStart is 1), powerGood is 0 whatever the values of slewMask and the window flags.
- R5: Once rampDone is seen in startup, the block regulates. With slewMask at 0, powerGood equals NOT overWin AND NOT underWin.
- R6: While regulating with slewMask at 1, powerGood is 1 whatever the window flags.
- R7: faultDet during startup or regulation sets faultLatched. While it is set, powerGood is 0 and rampStart is 0, whatever the values of slewMask and the window flags.
- R8: A latched fault survives an uvloOk drop and recovery. While it is latched, no dacSample pulse occurs and no ramp starts.
- R9: shutdownReq clears faultLatched and holds powerGood at 0 even with slewMask at 1. Releasing it with uvloOk high gives one new dacSample pulse and a new ramp.
- R10: Dropping porOk clears faultLatched. Raising porOk again with uvloOk high gives a fresh dacSample pulse.
- R11: faultDet has no effect on faultLatched during lockout or shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porOk | input | 1 | Supply above power-on-reset level |
| uvloOk | input | 1 | Supply above undervoltage-lockout level |
| overWin | input | 1 | Output above upper window limit |
| underWin | input | 1 | Output below lower window limit |
| faultDet | input | 1 | Fault detect |
| shutdownReq | input | 1 | Shutdown request |
| slewMask | input | 1 | Voltage transition in progress |
| rampDone | input | 1 | Startup ramp complete |
| powerGood | output | 1 | Power-good enable (1 = release the open-drain output) |
| lowGateForce | output | 1 | Force low-side gate on |
| dacSample | output | 1 | One-cycle strobe to sample the voltage-setting inputs |
| rampStart | output | 1 | Command to ramp the output |
| faultLatched | output | 1 | Fault latch state |

## Verification
A wrong sequencer state shows up directly at lowGateForce, rampStart and powerGood. It appears within the synchronizer depth plus one cycle of the input change that caused it, so the bench waits a fixed settle time and then compares all outputs with a priority model. A fault latch that clears on the wrong cause, or fails to hold, shows up as faultLatched or powerGood flipping after a UVLO dip or a stray faultDet. A lost or doubled sampling strobe shows up in the dacSample pulse count, which is tracked over every restart path.

// File: rtl/supply_supervisor_pkg.sv
package supply_supervisor_pkg;

  typedef struct packed {
    logic porOk;
    logic uvloOk;
    logic overWin;
    logic underWin;
    logic faultDet;
    logic shutdown;
    logic slewMask;
    logic rampDone;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_LOCK  = 3'd1,
    ST_START = 3'd2,
    ST_REG   = 3'd3,
    ST_SHUT  = 3'd4
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearFault;
    logic armFault;
    logic holdLow;
    logic underVolt;
  } ctl_t;

endpackage

// File: rtl/supply_supervisor_dp.sv
module supply_supervisor_dp
  import supply_supervisor_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  flags_t rawFlags,
  input  ctl_t   ctl,
  output flags_t syncFlags,
  output logic   faultQ,
  output logic   powerGood
);

  generate
    if (SYNC_STAGES == 0) begin : g_bypass
      assign syncFlags = rawFlags;
    end else begin : g_sync
      logic [FLAG_W-1:0] stagePipe [SYNC_STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < SYNC_STAGES; s++) stagePipe[s] <= '0;
        end else begin
          stagePipe[0] <= rawFlags;
          for (int s = 1; s < SYNC_STAGES; s++) stagePipe[s] <= stagePipe[s-1];
        end
      end
      assign syncFlags = flags_t'(stagePipe[SYNC_STAGES-1]);
    end
  endgenerate

  // fault latch: clear has priority over set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultQ <= 1'b0;
    end else if (ctl.clearFault) begin
      faultQ <= 1'b0;
    end else if (ctl.armFault && syncFlags.faultDet) begin
      faultQ <= 1'b1;
    end
  end

  // power-good priority chain
  always_comb begin
    if (ctl.underVolt) begin
      powerGood = 1'b0;
    end else if (faultQ) begin
      powerGood = 1'b0;
    end else if (ctl.holdLow) begin
      powerGood = 1'b0;
    end else if (syncFlags.slewMask) begin
      powerGood = 1'b1;
    end else begin
      powerGood = !syncFlags.overWin && !syncFlags.underWin;
    end
  end

endmodule

// File: rtl/supply_supervisor_ctrl.sv
module supply_supervisor_ctrl
  import supply_supervisor_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic porS,
  input  logic uvloS,
  input  logic shutS,
  input  logic doneS,
  input  logic faultQ,
  output ctl_t ctl,
  output logic lowGateForce,
  output logic rampStart,
  output logic dacSample
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    if (!porS) begin
      phaseNext = ST_OFF;
    end else if (shutS) begin
      phaseNext = ST_SHUT;
    end else if (!uvloS) begin
      phaseNext = ST_LOCK;
    end else begin
      case (phase)
        ST_OFF:   phaseNext = ST_LOCK;
        ST_LOCK:  phaseNext = faultQ ? ST_LOCK : ST_START;
        ST_START: phaseNext = (doneS && !faultQ) ? ST_REG : ST_START;
        ST_REG:   phaseNext = ST_REG;
        ST_SHUT:  phaseNext = ST_LOCK;
        default:  phaseNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_OFF;
      dacSample <= 1'b0;
    end else begin
      phase     <= phaseNext;
      dacSample <= (phase == ST_LOCK) && (phaseNext == ST_START);
    end
  end

  always_comb begin
    ctl.clearFault = !porS || shutS;
    ctl.armFault   = (phase == ST_START) || (phase == ST_REG);
    ctl.holdLow    = (phase == ST_START) || (phase == ST_SHUT);
    ctl.underVolt  = (phase == ST_OFF) || (phase == ST_LOCK);
  end

  assign lowGateForce = (phase == ST_OFF) || (phase == ST_LOCK);
  assign rampStart    = (phase == ST_START) && !faultQ;

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supply_supervisor_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic porOk,
  input  logic uvloOk,
  input  logic overWin,
  input  logic underWin,
  input  logic faultDet,
  input  logic shutdownReq,
  input  logic slewMask,
  input  logic rampDone,
  output logic powerGood,
  output logic lowGateForce,
  output logic dacSample,
  output logic rampStart,
  output logic faultLatched
);

  flags_t rawFlags;
  flags_t syncFlags;
  ctl_t   ctl;
  logic   faultQ;

  always_comb begin
    rawFlags.porOk    = porOk;
    rawFlags.uvloOk   = uvloOk;
    rawFlags.overWin  = overWin;
    rawFlags.underWin = underWin;
    rawFlags.faultDet = faultDet;
    rawFlags.shutdown = shutdownReq;
    rawFlags.slewMask = slewMask;
    rawFlags.rampDone = rampDone;
  end

  supply_supervisor_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawFlags  (rawFlags),
    .ctl       (ctl),
    .syncFlags (syncFlags),
    .faultQ    (faultQ),
    .powerGood (powerGood)
  );

  supply_supervisor_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .porS         (syncFlags.porOk),
    .uvloS        (syncFlags.uvloOk),
    .shutS        (syncFlags.shutdown),
    .doneS        (syncFlags.rampDone),
    .faultQ       (faultQ),
    .ctl          (ctl),
    .lowGateForce (lowGateForce),
    .rampStart    (rampStart),
    .dacSample    (dacSample)
  );

  assign faultLatched = faultQ;

endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic syncPor,
  input logic syncShut,
  input logic powerGood,
  input logic lowGateForce,
  input logic dacSample,
  input logic rampStart,
  input logic faultLatched
);

  assert_sample_onecycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    dacSample |=> !dacSample);

  assert_sample_starts_ramp_R3: assert property (@(posedge clk) disable iff (!rstN)
    dacSample |-> rampStart);

  assert_lockout_pg_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    lowGateForce |-> !powerGood);

  assert_start_pg_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    rampStart |-> !powerGood);

  assert_fault_pg_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (!powerGood && !rampStart));

  assert_no_sample_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> !dacSample);

  // clear cause is shutdown (R9) or supply below POR (R10)
  assert_fault_clear_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatched) |-> $past(syncShut || !syncPor));

endmodule

bind supply_supervisor supply_supervisor_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .syncPor      (syncFlags.porOk),
  .syncShut     (syncFlags.shutdown),
  .powerGood    (powerGood),
  .lowGateForce (lowGateForce),
  .dacSample    (dacSample),
  .rampStart    (rampStart),
  .faultLatched (faultLatched)
);

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porOk = 0, uvloOk = 0, overWin = 0, underWin = 0;
  logic faultDet = 0, shutdownReq = 0, slewMask = 0, rampDone = 0;
  logic powerGood, lowGateForce, dacSample, rampStart, faultLatched;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int wideErr = 0;
  logic prevSample = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  supply_supervisor uut (
    .clk(clk), .rstN(rstN), .porOk(porOk), .uvloOk(uvloOk),
    .overWin(overWin), .underWin(underWin), .faultDet(faultDet),
    .shutdownReq(shutdownReq), .slewMask(slewMask), .rampDone(rampDone),
    .powerGood(powerGood), .lowGateForce(lowGateForce), .dacSample(dacSample),
    .rampStart(rampStart), .faultLatched(faultLatched)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (dacSample) pulses++;
      if (dacSample && prevSample) wideErr++;
      prevSample = dacSample;
    end
  end

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic setWin(input int code);
    overWin  = code[0];
    underWin = code[1];
    slewMask = code[2];
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R1 reset state
    chk("R1 pg", powerGood, 0);
    chk("R1 lowGate", lowGateForce, 1);
    chk("R1 fault", faultLatched, 0);
    chk("R1 ramp", rampStart, 0);
    chk("R1 pulses", pulses, 0);

    // R2 / R11 lockout sweep
    porOk = 1;
    for (int c = 0; c < 16; c++) begin
      setWin(c);
      faultDet = c[3];
      settle();
      chk("R2 pg", powerGood, 0);
      chk("R2 lowGate", lowGateForce, 1);
      chk("R11 fault in lockout", faultLatched, 0);
    end
    faultDet = 0;
    setWin(0);

    // R3 startup
    uvloOk = 1;
    settle();
    chk("R3 pulses", pulses, 1);
    chk("R3 ramp", rampStart, 1);
    chk("R3 lowGate", lowGateForce, 0);
    for (int c = 0; c < 8; c++) begin
      setWin(c);
      settle();
      chk("R4 pg in startup", powerGood, 0);
    end

    // R5 / R6 regulation sweep
    rampDone = 1;
    settle();
    rampDone = 0;
    chk("R5 ramp off", rampStart, 0);
    for (int c = 0; c < 8; c++) begin
      setWin(c);
      settle();
      if (c[2]) chk("R6 mask pg", powerGood, 1);
      else chk("R5 window pg", powerGood, (!c[0] && !c[1]) ? 1 : 0);
    end
    setWin(0);
    settle();

    // R7 fault
    faultDet = 1;
    settle();
    faultDet = 0;
    chk("R7 latched", faultLatched, 1);
    for (int c = 0; c < 8; c++) begin
      setWin(c);
      settle();
      chk("R7 pg", powerGood, 0);
      chk("R7 ramp", rampStart, 0);
    end
    setWin(0);

    // R8 survives uvlo dip
    base = pulses;
    uvloOk = 0;
    settle();
    uvloOk = 1;
    settle();
    chk("R8 latched", faultLatched, 1);
    chk("R8 no pulse", pulses, base);
    chk("R8 ramp", rampStart, 0);
    chk("R8 pg", powerGood, 0);

    // R9 shutdown clears; R11 fault ignored in shutdown
    shutdownReq = 1;
    slewMask = 1;
    settle();
    chk("R9 cleared", faultLatched, 0);
    chk("R9 pg masked low", powerGood, 0);
    faultDet = 1;
    settle();
    faultDet = 0;
    chk("R11 fault in shutdown", faultLatched, 0);
    slewMask = 0;
    shutdownReq = 0;
    settle();
    chk("R9 restart pulse", pulses, base + 1);
    chk("R9 ramp", rampStart, 1);

    // R10 POR clear
    rampDone = 1;
    settle();
    rampDone = 0;
    faultDet = 1;
    settle();
    faultDet = 0;
    chk("R7 latched again", faultLatched, 1);
    base = pulses;
    porOk = 0;
    settle();
    chk("R10 cleared", faultLatched, 0);
    chk("R10 lowGate", lowGateForce, 1);
    chk("R1 pg below por", powerGood, 0);
    porOk = 1;
    settle();
    chk("R10 restart pulse", pulses, base + 1);
    chk("R10 ramp", rampStart, 1);
    chk("R3 pulse width", wideErr, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule